// File: doc/BRIEF.md
# Paged Bidirectional Digital I/O Register File

This block is the byte-wide register front end of a 48-line digital I/O controller. A host reaches it through a 4-bit address, a write strobe, a read strobe and 8-bit data buses. Six port registers set and sense the lines. Each line is an inverted open-drain output: a stored 1 pulls the pin low, and a stored 0 releases it. When released, an external pull-up holds the pin high and the line can serve as an input. Reads of a port return the complement of the pin levels, so a high pin reads as 0.

A control register holds two things: a page number that chooses which bank appears in a three-byte window, and a write lock for each port. Page 1 shows the edge-polarity bytes and page 2 shows the edge-enable bytes. Both are stored here and fed to an external edge-detect unit. Page 3 shows that unit's interrupt-ID bytes. A write to one of those bytes sends a one-cycle clear pulse back to the unit. A separate read-only summary address reports the unit's three pending flags.

Top module: `pio_regfile`

## Requirements
- R1: A write to address n (0 to 5) stores wdata into port n; pin_drive[8n+b] equals stored bit b, and 1 means the pin is pulled low.
- R2: Reading address n (0 to 5) returns the bitwise complement of pin_in[8n+7:8n].
- R3: Address 7 is the control register: wdata[7:6] selects page 0 to 3 and wdata[5:0] are lock bits, bit n belonging to port n; reading it returns the same byte.
- R4: A write to a port whose lock bit is 1 leaves that port's pin_drive unchanged, and reads of that port still return the inverted pins.
- R5: On page 1, addresses 8, 9 and 10 read and write polarity bytes 0, 1 and 2, which drive pol_out[7:0], [15:8] and [23:16].
- R6: On page 2, addresses 8, 9 and 10 read and write enable bytes 0 to 2, which drive en_out in the same byte order.
- R7: On page 3, addresses 8 to 10 read int_id bytes 0 to 2. A write to byte k sets id_clr to a one-hot value with only bit k high for exactly the cycle after the write edge.
- R8: Address 6 reads {5'b0, int_pend}. Writes to it have no effect.
- R9: With page 0 selected, addresses 8 to 10 read 0x00 and writes to them do nothing. Addresses 11 to 15 read 0x00 on any page and ignore writes.
- R10: Ports 0 to 5 and addresses 6 and 7 behave the same whatever page is selected.
- R11: A synchronous active-high reset clears the ports, page, locks, polarity, enable and id_clr, so every pin is released.
- R12: rdata is 0x00 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, enables rdata |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| pin_in | input | 48 | Sensed pin levels |
| pin_drive | output | 48 | 1 pulls the matching pin low |
| int_id | input | 24 | Interrupt-ID bits from the edge-detect unit |
| int_pend | input | 3 | Pending summary from the edge-detect unit |
| pol_out | output | 24 | Edge polarity per line to the edge-detect unit |
| en_out | output | 24 | Edge enable per line to the edge-detect unit |
| id_clr | output | 3 | One-cycle clear pulse per interrupt-ID byte |

## Verification
The directed tests come first. They write a port with an alternating pattern and set the external low pulls to zero, which shows whether the write and the inverted read use the same byte lanes. They then lock one port while leaving its neighbours unlocked, which separates a lock that is checked per port from one that is applied globally or to the wrong index. Window writes and reads under page 0, and reads of the unmapped addresses, show whether the window decode depends on the page.

A seeded random phase then mixes reads and writes across all sixteen addresses. It uses random data, random lock and page settings, and random external pulls on the pins. This exposes bank crossover between polarity and enable, wrong byte ordering inside the window, and clear pulses sent to the wrong lane.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int PORTS     = 6;
    localparam int WIN       = 3;
    localparam int LINES     = PORTS * 8;
    localparam int WBITS     = WIN * 8;
    localparam int AW        = 4;
    localparam int PEND_W    = 3;
    localparam int A_PEND    = 6;
    localparam int A_CTL     = 7;
    localparam int A_WIN     = 8;

    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_EN   = 2'd2,
        PG_ID   = 2'd3
    } page_e;

    typedef struct packed {
        logic       is_port;
        logic [2:0] port_sel;
        logic       is_pend;
        logic       is_ctl;
        logic       is_win;
        logic [1:0] win_sel;
    } dec_s;

    typedef struct packed {
        logic [LINES-1:0] drive;
        page_e            page;
        logic [PORTS-1:0] lock;
        logic [WBITS-1:0] pol;
        logic [WBITS-1:0] en;
        logic [WIN-1:0]   clr;
    } regs_s;
endpackage

// File: rtl/pio_addr_dec.sv
module pio_addr_dec
    import pio_pkg::*;
(
    input  logic [AW-1:0] addr,
    output dec_s          dec
);
    logic [AW-1:0] win_off;

    always_comb begin
        win_off      = addr - AW'(A_WIN);
        dec          = '0;
        dec.is_port  = (int'(addr) < PORTS);
        dec.port_sel = addr[2:0];
        dec.is_pend  = (int'(addr) == A_PEND);
        dec.is_ctl   = (int'(addr) == A_CTL);
        dec.is_win   = (int'(addr) >= A_WIN) && (int'(addr) < A_WIN + WIN);
        dec.win_sel  = win_off[1:0];
    end
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
    import pio_pkg::*;
(
    input  logic             rd_en,
    input  dec_s             dec,
    input  page_e            page,
    input  logic [PORTS-1:0] lock,
    input  logic [LINES-1:0] pin_in,
    input  logic [WBITS-1:0] pol,
    input  logic [WBITS-1:0] en,
    input  logic [WBITS-1:0] int_id,
    input  logic [PEND_W-1:0] int_pend,
    output logic [7:0]       rdata
);
    logic [7:0] port_rd [PORTS];
    logic [7:0] pol_rd  [WIN];
    logic [7:0] en_rd   [WIN];
    logic [7:0] id_rd   [WIN];

    for (genvar i = 0; i < PORTS; i++) begin : g_port
        assign port_rd[i] = ~pin_in[i*8 +: 8];
    end
    for (genvar k = 0; k < WIN; k++) begin : g_win
        assign pol_rd[k] = pol[k*8 +: 8];
        assign en_rd[k]  = en[k*8 +: 8];
        assign id_rd[k]  = int_id[k*8 +: 8];
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            if (dec.is_port) begin
                rdata = port_rd[dec.port_sel];
            end else if (dec.is_pend) begin
                rdata = {{(8-PEND_W){1'b0}}, int_pend};
            end else if (dec.is_ctl) begin
                rdata = {page, lock};
            end else if (dec.is_win) begin
                case (page)
                    PG_POL:  rdata = pol_rd[dec.win_sel];
                    PG_EN:   rdata = en_rd[dec.win_sel];
                    PG_ID:   rdata = id_rd[dec.win_sel];
                    default: rdata = 8'h00;
                endcase
            end
        end
    end
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_drive,
    input  logic [WBITS-1:0]  int_id,
    input  logic [PEND_W-1:0] int_pend,
    output logic [WBITS-1:0]  pol_out,
    output logic [WBITS-1:0]  en_out,
    output logic [WIN-1:0]    id_clr
);
    dec_s  dec;
    regs_s regs_d, regs_q;

    pio_addr_dec u_dec (
        .addr (addr),
        .dec  (dec)
    );

    // next-state: one write per cycle, lock guards only the port registers
    always_comb begin
        regs_d     = regs_q;
        regs_d.clr = '0;
        if (wr_en) begin
            if (dec.is_port && !regs_q.lock[dec.port_sel]) begin
                regs_d.drive[{dec.port_sel, 3'b000} +: 8] = wdata;
            end
            if (dec.is_ctl) begin
                regs_d.page = page_e'(wdata[7:6]);
                regs_d.lock = wdata[PORTS-1:0];
            end
            if (dec.is_win) begin
                case (regs_q.page)
                    PG_POL:  regs_d.pol[{dec.win_sel, 3'b000} +: 8] = wdata;
                    PG_EN:   regs_d.en[{dec.win_sel, 3'b000} +: 8]  = wdata;
                    PG_ID:   regs_d.clr[dec.win_sel] = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign pin_drive = regs_q.drive;
    assign pol_out   = regs_q.pol;
    assign en_out    = regs_q.en;
    assign id_clr    = regs_q.clr;

    pio_rd_mux u_rd (
        .rd_en    (rd_en),
        .dec      (dec),
        .page     (regs_q.page),
        .lock     (regs_q.lock),
        .pin_in   (pin_in),
        .pol      (regs_q.pol),
        .en       (regs_q.en),
        .int_id   (int_id),
        .int_pend (int_pend),
        .rdata    (rdata)
    );

    // locked port write must not move any pin
    assert_locked_port_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.is_port && regs_q.lock[dec.port_sel]) |=> $stable(pin_drive));

    // reset leaves everything released and idle
    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (pin_drive == '0 && pol_out == '0 && en_out == '0 && id_clr == '0));

    // dead addresses and page-0 window never change state
    assert_dead_write_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ((!dec.is_port && !dec.is_ctl && !dec.is_win) ||
                   (dec.is_win && regs_q.page == PG_NONE)))
        |=> ($stable(pin_drive) && $stable(pol_out) && $stable(en_out) && id_clr == '0));

    // polarity-page writes leave enables alone
    assert_pol_isolated_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.is_win && regs_q.page == PG_POL) |=> $stable(en_out));

    // enable-page writes leave polarity alone
    assert_en_isolated_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.is_win && regs_q.page == PG_EN) |=> $stable(pol_out));

    // id-page write yields exactly one clear lane
    assert_clr_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.is_win && regs_q.page == PG_ID) |=> ($countones(id_clr) == 1));

    // pending summary keeps its upper bits zero
    assert_pend_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(addr) == A_PEND) |-> (rdata == {{(8-PEND_W){1'b0}}, int_pend}));

    // idle read bus
    assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == 8'h00));
endmodule

// File: tb/sim_pio_regfile.sv
`timescale 1ns/1ps
module sim_pio_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] pin_in;
    logic [47:0] pin_drive;
    logic [23:0] int_id = '0;
    logic [2:0]  int_pend = '0;
    logic [23:0] pol_out, en_out;
    logic [2:0]  id_clr;
    logic [47:0] ext_low = '0;

    int nchk = 0;
    int nerr = 0;

    // model state
    logic [47:0] m_drv;
    logic [1:0]  m_page;
    logic [5:0]  m_lock;
    logic [23:0] m_pol, m_en;
    logic [2:0]  m_clr;

    always #10 clk = ~clk;

    // pin is low if the block or the outside world pulls it
    assign pin_in = ~pin_drive & ~ext_low;

    pio_regfile u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_drive(pin_drive),
        .int_id(int_id), .int_pend(int_pend), .pol_out(pol_out),
        .en_out(en_out), .id_clr(id_clr)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        if (a < 6)  return m_drv[a*8 +: 8] | ext_low[a*8 +: 8];
        if (a == 6) return {5'b0, int_pend};
        if (a == 7) return {m_page, m_lock};
        if (a >= 8 && a <= 10) begin
            case (m_page)
                2'd1: return m_pol[(a-8)*8 +: 8];
                2'd2: return m_en[(a-8)*8 +: 8];
                2'd3: return int_id[(a-8)*8 +: 8];
                default: return 8'h00;
            endcase
        end
        return 8'h00;
    endfunction

    function automatic string rd_tag(input int a);
        if (a < 6)  return (m_page != 0) ? "R10" : "R2";
        if (a == 6) return "R8";
        if (a == 7) return "R3";
        if (a >= 8 && a <= 10) begin
            case (m_page)
                2'd1: return "R5";
                2'd2: return "R6";
                2'd3: return "R7";
                default: return "R9";
            endcase
        end
        return "R9";
    endfunction

    task automatic model_reset();
        m_drv = '0; m_page = '0; m_lock = '0; m_pol = '0; m_en = '0; m_clr = '0;
    endtask

    task automatic check_outs(input string drv_tag);
        chk(pin_drive == m_drv, drv_tag, pin_drive, m_drv);
        chk(pol_out == m_pol, "R5", pol_out, m_pol);
        chk(en_out == m_en, "R6", en_out, m_en);
        chk(id_clr == m_clr, "R7", id_clr, m_clr);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        string t;
        t = "R1";
        @(negedge clk);
        addr = 4'(a); wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        m_clr = '0;
        if (a < 6) begin
            if (m_lock[a]) t = "R4";
            else m_drv[a*8 +: 8] = d;
        end else if (a == 7) begin
            m_page = d[7:6]; m_lock = d[5:0]; t = "R3";
        end else if (a >= 8 && a <= 10) begin
            case (m_page)
                2'd1: m_pol[(a-8)*8 +: 8] = d;
                2'd2: m_en[(a-8)*8 +: 8] = d;
                2'd3: m_clr[a-8] = 1'b1;
                default: t = "R9";
            endcase
        end else begin
            t = "R9";
        end
        @(negedge clk);
        wr_en = 1'b0;
        check_outs(t);
        m_clr = '0;
    endtask

    task automatic rd(input int a);
        @(negedge clk);
        addr = 4'(a); rd_en = 1'b1; wr_en = 1'b0;
        #2;
        chk(rdata == exp_rd(a), rd_tag(a), rdata, exp_rd(a));
        #2;
        rd_en = 1'b0;
        #1;
        chk(rdata == 8'h00, "R12", rdata, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check_outs("R11");
        rd(7);

        // R1 / R2 directed alternating pattern
        wr(2, 8'hA5);
        rd(2);
        ext_low[16 +: 8] = 8'h0F;
        rd(2);
        ext_low = '0;
        // R4 lock port 2 only
        wr(7, 8'b00_000100);
        wr(2, 8'hFF);
        wr(3, 8'h3C);
        rd(2);
        rd(3);
        // R9 page 0 window and unmapped
        wr(8, 8'h77);
        wr(12, 8'h55);
        wr(6, 8'hFF);
        rd(8);
        rd(13);
        // R5 / R6 / R7 pages
        wr(7, 8'b01_000000);
        wr(9, 8'hC3);
        rd(9);
        rd(1);
        wr(7, 8'b10_000000);
        wr(10, 8'h81);
        rd(10);
        int_id = 24'h123456;
        int_pend = 3'b101;
        wr(7, 8'b11_000000);
        rd(8);
        rd(6);
        wr(9, 8'h00);
        wr(15, 8'h00);

        // constrained random
        for (int i = 0; i < 600; i++) begin
            int a;
            a = int'($urandom_range(0, 15));
            if ($urandom_range(0, 9) == 0) ext_low = {$urandom(), $urandom()};
            if ($urandom_range(0, 7) == 0) begin
                int_id = 24'($urandom());
                int_pend = 3'($urandom());
            end
            if ($urandom_range(0, 1) == 0) begin
                logic [7:0] d;
                d = 8'($urandom());
                if (a == 7) d[5:0] = d[5:0] & 6'($urandom()) & 6'($urandom());
                wr(a, d);
            end else begin
                rd(a);
            end
        end

        // R11 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_outs("R11");
        rd(7);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule